// File: doc/BRIEF.md
# Serial OSD Command Decoder

This block receives 8-bit words from a host over a three-wire serial port (clock, data, active-low select). Bits arrive most significant first and are sampled on the rising edge of the serial clock. A word with bit 7 set chooses one of eleven commands. A word with bit 7 clear carries data for the command that is currently selected. That command stays selected until another command word arrives. The decoder keeps a row/column write address for a 12 x 24 character display memory. It also keeps a register file of display-control fields, and every field is visible on an output.

A character-write command puts the decoder into a locked streaming mode. In that mode every word, whatever its bit 7, is a character code. Each code is written to the current cell with the attribute bit captured from the command word, and the address then advances. Raising select ends the stream and returns the decoder to address setup. A control command can sweep the whole memory with the blank code 0xFF. Another control bit holds every register at zero until select next rises.

Memory writes leave on a valid/ready port. `wr_valid` rises with `wr_row`, `wr_col` and `wr_data`, and all four hold still until `wr_ready` is seen high on a clock edge. The port never takes back a write it has offered. The serial port has no back-pressure. A character that completes while a write is still pending, or while an erase sweep runs, is dropped, and the address does not advance. Control pins are plain levels.

Top module: `osd_cmd_decoder`

## Requirements
- R1: After reset, `cur_cmd`, `addr_row`, `addr_col`, `cfg_hi`, `cfg_lo`, `char_lock`, `sys_hold`, `erase_busy` and `wr_valid` are all zero.
- R2: Words are assembled most significant bit first from 8 rising serial-clock edges while select is low. A partial word present when select rises is discarded, so the next word starts cleanly.
- R3: The address-setup command word `1000rrrr` sets the row to rrrr. Its data word `000ccccc` sets the column to ccccc. A row above 11 or a column above 23 is ignored and leaves the old value. `addr_row` and `addr_col` show the current address.
- R4: A command word for command k (2 to 10) sets `cur_cmd` to k and stores its low field in `cfg_hi[4*(k-2)+:4]`. Each following data word stores its bits 6:0 in `cfg_lo[7*(k-2)+:7]`, and the command stays selected across any number of data words.
- R5: Command codes are decoded as follows.
  - Words `1010`, `1011`, `1100`, `1101` and `1110` (upper nibble) select commands 2 to 6, and their low nibble is stored.
  - Words `111100xx`, `111101xx`, `111110xx` and `111111xx` select commands 7 to 10, and only xx is stored, zero-extended.
  - A word `1001` with a nonzero bit 3, 2 or 1 is ignored and leaves `cur_cmd` unchanged.
- R6: The word `1001000a` sets `cur_cmd` to 1 and raises `char_lock`. From then on, every word, including words with bit 7 set, is written as `wr_data = {a, code}` to the current address.
- R7: After each character write the column increments. After column 23 the column wraps to 0 and the row increments, and row 11 wraps to row 0.
- R8: When select rises, `cur_cmd` returns to 0 and `char_lock` clears.
- R9: A control word (upper nibble `1100`) with bit 0 set clears every register, including the address and all config fields, and raises `sys_hold`. While the hold is active, all words are ignored. The hold releases when select rises.
- R10: A control word with bit 2 set starts an erase sweep. The sweep writes `wr_data = 9'h0FF` to all 288 cells in row-major order, and `erase_busy` is high while it runs.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_row`, `wr_col` and `wr_data` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial port |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, data taken on rising edge |
| sdat | input | 1 | Serial data |
| wr_valid | output | 1 | Memory write offered |
| wr_ready | input | 1 | Memory accepts the write |
| wr_row | output | 4 | Write row (0-11) |
| wr_col | output | 5 | Write column (0-23) |
| wr_data | output | 9 | {attribute, character code} |
| cur_cmd | output | 4 | Selected command number 0-10 |
| char_lock | output | 1 | Character streaming mode active |
| sys_hold | output | 1 | Register hold active |
| erase_busy | output | 1 | Erase sweep in progress |
| addr_row | output | 4 | Current write row |
| addr_col | output | 5 | Current write column |
| cfg_hi | output | 36 | Command-word fields, 4 bits per command 2-10 |
| cfg_lo | output | 63 | Data-word fields, 7 bits per command 2-10 |

## Verification
The decoder is driven with directed address words, including out-of-range rows and columns, which separate accepted values from ignored ones. Character streams are sent that contain codes with bit 7 set and that cross the last column and the last row, which checks both the lock and the address wrap. Seeded random sequences of command words, with random low fields and several data words each, go to commands 2 to 10 and show whether each field lands in its own slot and persists. Separate sequences cover a truncated word, the hold-and-release, and the erase sweep. A randomly stalling `wr_ready` runs throughout, so that every write the model memory records has survived back-pressure.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int WORD_W  = 8;
  localparam int CMD_N   = 11;
  localparam int CFG_N   = CMD_N - 2;
  localparam int HI_W    = 4;
  localparam int LO_W    = 7;
  localparam int CMD_W   = $clog2(CMD_N);
  localparam int DATA_W  = WORD_W + 1;

  localparam logic [CMD_W-1:0] CMD_ADDR = 4'd0;
  localparam logic [CMD_W-1:0] CMD_CHAR = 4'd1;
  localparam logic [CMD_W-1:0] CMD_CTRL = 4'd4;

  localparam logic [DATA_W-1:0] BLANK_WORD = {1'b0, 8'hFF};
endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx
  import osd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdat,
  output logic              byte_vld,
  output logic [WORD_W-1:0] byte_dat,
  output logic              sel_rise,
  output logic              sel_act
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [2:0] sclk_s;
  logic [1:0] sdat_s;
  logic [2:0] sel_s;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 3'b111;
      sdat_s <= 2'b11;
      sel_s  <= 3'b111;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      sdat_s <= {sdat_s[0], sdat};
      sel_s  <= {sel_s[1:0], sel_n};
    end
  end

  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign sel_act   = ~sel_s[1];
  assign sel_rise  = sel_s[1] & ~sel_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!sel_act) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        sh_q <= {sh_q[WORD_W-2:0], sdat_s[1]};
        if (int'(cnt_q) == WORD_W - 1) begin
          byte_vld <= 1'b1;
          byte_dat <= {sh_q[WORD_W-2:0], sdat_s[1]};
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R2
  bit_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> (cnt_q == '0));
endmodule

// File: rtl/osd_cmd_fsm.sv
module osd_cmd_fsm
  import osd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 24,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_vld,
  input  logic [WORD_W-1:0]       byte_dat,
  input  logic                    sel_rise,
  input  logic                    wr_busy,
  output logic                    char_req,
  output logic [DATA_W-1:0]       char_data,
  output logic                    erase_start,
  output logic [CMD_W-1:0]        cur_cmd,
  output logic                    char_lock,
  output logic                    sys_hold,
  output logic [RW-1:0]           row_q,
  output logic [CW-1:0]           col_q,
  output logic [CFG_N*HI_W-1:0]   cfg_hi,
  output logic [CFG_N*LO_W-1:0]   cfg_lo
);
  logic [CFG_N-1:0][HI_W-1:0] hi_q;
  logic [CFG_N-1:0][LO_W-1:0] lo_q;
  logic attr_q;
  logic [CMD_W-1:0] dec;
  logic dec_ok, is_ext;
  logic [HI_W-1:0] hi_val;
  logic [CMD_W-1:0] dslot, cslot;
  logic take;

  always_comb begin
    dec_ok = 1'b1;
    is_ext = (byte_dat[6:4] == 3'd7);
    case (byte_dat[6:4])
      3'd0: dec = CMD_ADDR;
      3'd1: begin
        dec    = CMD_CHAR;
        dec_ok = (byte_dat[3:1] == 3'b000);
      end
      3'd7: dec = 4'd7 + {2'b00, byte_dat[3:2]};
      default: dec = {1'b0, byte_dat[6:4]};
    endcase
    hi_val = is_ext ? {2'b00, byte_dat[1:0]} : byte_dat[3:0];
    dslot  = dec - 4'd2;
    cslot  = cur_cmd - 4'd2;
  end

  assign take      = byte_vld & ~sel_rise & ~sys_hold;
  assign char_req  = take & char_lock & ~wr_busy;
  assign char_data = {attr_q, byte_dat};
  assign cfg_hi    = hi_q;
  assign cfg_lo    = lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cmd     <= CMD_ADDR;
      char_lock   <= 1'b0;
      sys_hold    <= 1'b0;
      attr_q      <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      erase_start <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      if (sel_rise) begin
        cur_cmd   <= CMD_ADDR;
        char_lock <= 1'b0;
        sys_hold  <= 1'b0;
      end else if (take) begin
        if (char_lock) begin
          if (!wr_busy) begin
            if (int'(col_q) == COLS - 1) begin
              col_q <= '0;
              row_q <= (int'(row_q) == ROWS - 1) ? '0 : row_q + 1'b1;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end
        end else if (byte_dat[7]) begin
          if (dec_ok) begin
            cur_cmd <= dec;
            if (dec == CMD_ADDR) begin
              if (int'(byte_dat[3:0]) < ROWS) row_q <= RW'(byte_dat[3:0]);
            end else if (dec == CMD_CHAR) begin
              attr_q    <= byte_dat[0];
              char_lock <= 1'b1;
            end else begin
              hi_q[dslot] <= hi_val;
              if (dec == CMD_CTRL && byte_dat[2]) erase_start <= 1'b1;
              if (dec == CMD_CTRL && byte_dat[0]) begin
                sys_hold <= 1'b1;
                attr_q   <= 1'b0;
                row_q    <= '0;
                col_q    <= '0;
                hi_q     <= '0;
                lo_q     <= '0;
              end
            end
          end
        end else begin
          if (cur_cmd == CMD_ADDR) begin
            if (int'(byte_dat[4:0]) < COLS) col_q <= CW'(byte_dat[4:0]);
          end else if (cur_cmd != CMD_CHAR) begin
            lo_q[cslot] <= byte_dat[LO_W-1:0];
          end
        end
      end
    end
  end

  // R8
  sel_rise_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> (cur_cmd == CMD_ADDR) && !char_lock);

  // R6
  lock_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_lock |-> (cur_cmd == CMD_CHAR));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(row_q) < ROWS) && (int'(col_q) < COLS));
endmodule

// File: rtl/osd_wr_port.sv
module osd_wr_port
  import osd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 24,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_req,
  input  logic [RW-1:0]     char_row,
  input  logic [CW-1:0]     char_col,
  input  logic [DATA_W-1:0] char_data,
  input  logic              erase_start,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [RW-1:0]     wr_row,
  output logic [CW-1:0]     wr_col,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              erase_busy
);
  logic [RW-1:0] e_row;
  logic [CW-1:0] e_col;

  assign busy = wr_valid | erase_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_row     <= '0;
      wr_col     <= '0;
      wr_data    <= '0;
      erase_busy <= 1'b0;
      e_row      <= '0;
      e_col      <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (!wr_valid) begin
        if (erase_busy) begin
          wr_valid <= 1'b1;
          wr_row   <= e_row;
          wr_col   <= e_col;
          wr_data  <= BLANK_WORD;
          if (int'(e_col) == COLS - 1) begin
            e_col <= '0;
            if (int'(e_row) == ROWS - 1) begin
              e_row      <= '0;
              erase_busy <= 1'b0;
            end else begin
              e_row <= e_row + 1'b1;
            end
          end else begin
            e_col <= e_col + 1'b1;
          end
        end else if (char_req) begin
          wr_valid <= 1'b1;
          wr_row   <= char_row;
          wr_col   <= char_col;
          wr_data  <= char_data;
        end
      end
      if (erase_start) begin
        erase_busy <= 1'b1;
        e_row      <= '0;
        e_col      <= '0;
      end
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_row) && $stable(wr_col) && $stable(wr_data));

  // R10
  erase_last_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_busy) |-> wr_valid && (int'(wr_row) == ROWS - 1) && (int'(wr_col) == COLS - 1)
                          && (wr_data == BLANK_WORD));
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 24,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_n,
  input  logic                  sclk,
  input  logic                  sdat,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [RW-1:0]         wr_row,
  output logic [CW-1:0]         wr_col,
  output logic [DATA_W-1:0]     wr_data,
  output logic [CMD_W-1:0]      cur_cmd,
  output logic                  char_lock,
  output logic                  sys_hold,
  output logic                  erase_busy,
  output logic [RW-1:0]         addr_row,
  output logic [CW-1:0]         addr_col,
  output logic [CFG_N*HI_W-1:0] cfg_hi,
  output logic [CFG_N*LO_W-1:0] cfg_lo
);
  logic              byte_vld, sel_rise, sel_act;
  logic [WORD_W-1:0] byte_dat;
  logic              char_req, erase_start, wr_busy;
  logic [DATA_W-1:0] char_data;

  osd_ser_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .sclk     (sclk),
    .sdat     (sdat),
    .byte_vld (byte_vld),
    .byte_dat (byte_dat),
    .sel_rise (sel_rise),
    .sel_act  (sel_act)
  );

  osd_cmd_fsm #(.ROWS(ROWS), .COLS(COLS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .byte_dat    (byte_dat),
    .sel_rise    (sel_rise),
    .wr_busy     (wr_busy),
    .char_req    (char_req),
    .char_data   (char_data),
    .erase_start (erase_start),
    .cur_cmd     (cur_cmd),
    .char_lock   (char_lock),
    .sys_hold    (sys_hold),
    .row_q       (addr_row),
    .col_q       (addr_col),
    .cfg_hi      (cfg_hi),
    .cfg_lo      (cfg_lo)
  );

  osd_wr_port #(.ROWS(ROWS), .COLS(COLS)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_req    (char_req),
    .char_row    (addr_row),
    .char_col    (addr_col),
    .char_data   (char_data),
    .erase_start (erase_start),
    .wr_ready    (wr_ready),
    .wr_valid    (wr_valid),
    .wr_row      (wr_row),
    .wr_col      (wr_col),
    .wr_data     (wr_data),
    .busy        (wr_busy),
    .erase_busy  (erase_busy)
  );

  // R9
  hold_no_write_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_hold && !wr_valid && !erase_busy) |=> !wr_valid);
endmodule

// File: tb/osd_cmd_decoder_tb.sv
`timescale 1ns/1ps
module osd_cmd_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b1, sdat = 1'b1, wr_ready = 1'b0;
  logic wr_valid, char_lock, sys_hold, erase_busy;
  logic [3:0] wr_row, addr_row, cur_cmd;
  logic [4:0] wr_col, addr_col;
  logic [8:0] wr_data;
  logic [35:0] cfg_hi;
  logic [62:0] cfg_lo;

  always #2 clk = ~clk;

  osd_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdat(sdat),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .cur_cmd(cur_cmd), .char_lock(char_lock), .sys_hold(sys_hold),
    .erase_busy(erase_busy), .addr_row(addr_row), .addr_col(addr_col),
    .cfg_hi(cfg_hi), .cfg_lo(cfg_lo)
  );

  int n_run = 0, n_fail = 0, stall_cnt = 0;
  bit done = 0;
  logic [8:0] mem [12][24];
  logic [3:0] exp_hi [9];
  logic [6:0] exp_lo [9];
  int er, ec;
  logic prev_stall = 1'b0;
  logic [17:0] prev_pay;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // write monitor and R11 stability observer
  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        n_run++;
        if (!(wr_valid && {wr_row, wr_col, wr_data} == prev_pay)) begin
          n_fail++;
          $display("FAIL R11 stall payload: actual %0h expected %0h", {wr_valid, wr_row, wr_col, wr_data}, {1'b1, prev_pay});
        end
      end
      if (wr_valid && !wr_ready) stall_cnt++;
      prev_stall = wr_valid && !wr_ready;
      prev_pay = {wr_row, wr_col, wr_data};
      if (wr_valid && wr_ready) mem[wr_row][wr_col] = wr_data;
    end
  end

  always @(negedge clk) if (rst_n) wr_ready <= (($urandom % 4) != 0);

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sclk = 1'b0; sdat = b[i]; wclk(4);
      sclk = 1'b1; wclk(4);
    end
    wclk(8);
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic sel_lo(); sel_n = 1'b0; wclk(8); endtask
  task automatic sel_hi(); wclk(4); sel_n = 1'b1; wclk(10); endtask

  function automatic logic [7:0] first_code(input int k, input logic [3:0] low);
    if (k <= 6) return {1'b1, 3'(k), low};
    return {4'hF, 2'(k - 7), low[1:0]};
  endfunction

  function automatic logic [3:0] hi_of(input int k, input logic [3:0] low);
    return (k >= 7) ? {2'b00, low[1:0]} : low;
  endfunction

  task automatic chk_cfg(input string req);
    for (int k = 0; k < 9; k++) begin
      chk(req, $sformatf("cfg_hi slot %0d", k), 64'(cfg_hi[4*k +: 4]), 64'(exp_hi[k]));
      chk(req, $sformatf("cfg_lo slot %0d", k), 64'(cfg_lo[7*k +: 7]), 64'(exp_lo[k]));
    end
  endtask

  task automatic advance();
    if (ec == 23) begin ec = 0; er = (er == 11) ? 0 : er + 1; end
    else ec++;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] code;
    logic [3:0] low;
    int k, nd, errs;
    void'($urandom(32'd1234));
    for (int r = 0; r < 12; r++) for (int c = 0; c < 24; c++) mem[r][c] = 9'h155;
    for (int i = 0; i < 9; i++) begin exp_hi[i] = '0; exp_lo[i] = '0; end
    wclk(5); rst_n = 1'b1; wclk(5);

    // R1 reset state
    chk("R1", "cur_cmd", 64'(cur_cmd), 0);
    chk("R1", "addr", 64'({addr_row, addr_col}), 0);
    chk("R1", "flags", 64'({char_lock, sys_hold, erase_busy, wr_valid}), 0);
    chk("R1", "cfg", 64'(|{cfg_hi, cfg_lo}), 0);

    // R3 address setup, MSB-first assembly (R2)
    sel_lo(); send_byte(8'h85); send_byte(8'h13); sel_hi();
    chk("R3", "row", 64'(addr_row), 5);
    chk("R3", "col", 64'(addr_col), 19);
    chk("R8", "cmd after select high", 64'(cur_cmd), 0);
    sel_lo(); send_byte(8'h8C); send_byte(8'h18); sel_hi();
    chk("R3", "row out of range ignored", 64'(addr_row), 5);
    chk("R3", "col out of range ignored", 64'(addr_col), 19);

    // R6 / R7 character streaming
    er = 5; ec = 19;
    sel_lo(); send_byte(8'h91);
    chk("R6", "lock", 64'({char_lock, cur_cmd}), 64'({1'b1, 4'd1}));
    send_byte(8'hA5);
    chk("R6", "first-byte code as data", 64'(cur_cmd), 1);
    wclk(20);
    chk("R6", "cell 5,19", 64'(mem[5][19]), 64'(9'h1A5));
    advance();
    for (int i = 0; i < 5; i++) begin
      code = 8'($urandom);
      send_byte(code); wclk(20);
      chk("R7", $sformatf("cell %0d,%0d", er, ec), 64'(mem[er][ec]), 64'({1'b1, code}));
      advance();
    end
    sel_hi();
    chk("R8", "unlock", 64'({char_lock, cur_cmd}), 0);
    chk("R7", "wrapped address", 64'({addr_row, addr_col}), 64'({4'd6, 5'd1}));

    // R7 last row wraps to row 0
    sel_lo(); send_byte(8'h8B); send_byte(8'h17); sel_hi();
    sel_lo(); send_byte(8'h90); send_byte(8'h3C); wclk(20); sel_hi();
    chk("R7", "cell 11,23", 64'(mem[11][23]), 64'(9'h03C));
    chk("R7", "row wrap", 64'({addr_row, addr_col}), 0);

    // R4 / R5 random configuration commands
    for (int it = 0; it < 20; it++) begin
      k = 2 + int'($urandom % 9);
      low = 4'($urandom);
      if (k == 4) low = low & 4'b1010;
      sel_lo(); send_byte(first_code(k, low));
      exp_hi[k-2] = hi_of(k, low);
      chk("R5", "cur_cmd", 64'(cur_cmd), 64'(k));
      nd = 1 + int'($urandom % 3);
      for (int d = 0; d < nd; d++) begin
        code = {1'b0, 7'($urandom)};
        send_byte(code);
        exp_lo[k-2] = code[6:0];
      end
      chk("R4", "cmd persists", 64'(cur_cmd), 64'(k));
      sel_hi();
      chk_cfg("R4");
    end

    // R5 invalid character-write variant ignored
    sel_lo(); send_byte(8'hB6); exp_hi[1] = 4'h6;
    send_byte(8'h9A);
    chk("R5", "bad code ignored", 64'(cur_cmd), 3);
    send_byte(8'h4D); exp_lo[1] = 7'h4D; sel_hi();
    chk_cfg("R5");

    // R2 partial word discarded
    sel_lo(); send_bits(8'hFF, 5); sel_hi();
    sel_lo(); send_byte(8'h83); send_byte(8'h02); sel_hi();
    chk("R2", "addr after partial", 64'({addr_row, addr_col}), 64'({4'd3, 5'd2}));

    // R9 system hold
    sel_lo(); send_byte(8'hC1);
    chk("R9", "hold", 64'({sys_hold, addr_row, addr_col}), 64'({1'b1, 9'd0}));
    for (int i = 0; i < 9; i++) begin exp_hi[i] = '0; exp_lo[i] = '0; end
    chk_cfg("R9");
    send_byte(8'hB3); send_byte(8'h25); send_byte(8'h85);
    chk("R9", "words ignored", 64'({cfg_hi[7:4], cfg_lo[13:7], addr_row}), 0);
    sel_hi();
    chk("R9", "release", 64'(sys_hold), 0);
    sel_lo(); send_byte(8'hB3); send_byte(8'h25); sel_hi();
    chk("R9", "works after release", 64'({cfg_hi[7:4], cfg_lo[13:7]}), 64'({4'h3, 7'h25}));

    // R10 erase sweep
    sel_lo(); send_byte(8'hC4); sel_hi();
    chk("R10", "busy", 64'(erase_busy), 1);
    wclk(2500);
    chk("R10", "done", 64'({erase_busy, wr_valid}), 0);
    errs = 0;
    for (int r = 0; r < 12; r++) for (int c = 0; c < 24; c++) if (mem[r][c] !== 9'h0FF) errs++;
    chk("R10", "cells not blank", 64'(errs), 0);

    chk("R11", "back-pressure exercised", 64'(stall_cnt > 0), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule